// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block is a slave on a two-wire serial bus (I2C-compatible) that holds a 128 x 8 storage array. A fast system clock samples the serial clock and data lines. The block finds START and STOP conditions and decodes the device select byte. Writes are buffered a page at a time. Reads come from an internal byte counter that advances on its own. The data line is never driven high. The block only asserts an open-drain pull-down enable, and the board or bench forms the wired-AND with the master.

A write sends a word address and then one or more data bytes. These bytes collect in an eight-lane page buffer and go to the array only when a STOP arrives. The STOP also starts a self-timed write cycle of a fixed number of system clocks. While that cycle runs, the slave ignores its own address, so a master polls with repeated STARTs until it gets an acknowledge. A random read is a write with an address and no data, followed by a repeated START and a read select. Reads continue for as long as the master acknowledges. A write-control input that is low at STOP throws the buffered data away, and reads still work.

Top module: `twi_eeprom`

## Requirements
- R1: After reset the data line is released (`sda_oe_o` = 0), and every one of the 128 locations reads back as 8'hFF.
- R2: A device select byte whose upper four bits are 4'b1010 is acknowledged. Bits 3..1 are don't-care, and bit 0 selects read (1) or write (0). A byte with any other upper nibble gets no acknowledge, and the slave ignores the bus until the next START.
- R3: In a write, the byte after the device select is the word address (bit 7 ignored). Each following data byte is acknowledged and buffered. The buffered bytes are stored at STOP.
- R4: Within a write, the three low address bits advance modulo 8 and the upper four stay fixed. A later byte that lands on the same location replaces the earlier one.
- R5: A STOP that stores data starts a write cycle of WR_CYCLES system clocks. During that cycle no device select byte is acknowledged. After the cycle a device select byte is acknowledged again.
- R6: A repeated START after a word address (dummy write) stores nothing. The read select that follows returns the byte at that address.
- R7: A current-address read returns the byte at the internal counter and then advances the counter by one. After a write, the counter points at the location that follows the last accepted data byte, taken modulo 8 within the page.
- R8: In a read, each byte the master acknowledges is followed by the byte at the next address. The counter wraps from 7'h7F to 7'h00.
- R9: If `wr_en_i` is low at STOP, no location changes and no write cycle starts: the next device select is acknowledged at once.
- R10: The master's acknowledge is sampled in the ninth clock of each read byte. A missing acknowledge ends the read. The slave then releases the line and ignores the bus until the next START.
- R11: `sda_oe_o` changes only just after an SCL falling edge, a START or a STOP. It is high only for an acknowledge slot or for a zero data bit being sent. A STOP always releases it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level (wired-AND result) |
| wr_en_i | input | 1 | Write control; low blocks storing at STOP |
| sda_oe_o | output | 1 | Pull-down enable for the data line (1 drives low) |

## Verification
The bench writes 10 bytes into one page and expects the last two to overwrite the first two. A design that carried the page address would instead corrupt the next page, and one that stored bytes as they arrived would leave wrong data after the wrap. It polls right after STOP and expects the first select to be refused. A design with no busy window would acknowledge at once, and one that counted the window wrongly would never acknowledge. Reads that cross 7'h7F must return location 0. A dummy write must leave memory untouched, which catches a design that stores on repeated START. A write with write control low must change nothing and must not block the next select. A bad select code and a read ended by a missing acknowledge are each followed by bytes that must go unanswered, which exposes a slave that keeps listening.

// File: rtl/eep_pkg.sv
package eep_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_ACK,
        ST_TX,
        ST_MACK
    } eep_state_e;

    typedef enum logic [1:0] {
        RX_DEV,
        RX_WADDR,
        RX_WDATA
    } rx_kind_e;

    localparam logic [3:0] DEV_CODE = 4'b1010;

    typedef struct packed {
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_ev_t;

    function automatic logic dev_match(input logic [7:0] sel);
        return sel[7:4] == DEV_CODE;
    endfunction

endpackage

// File: rtl/eep_line_sync.sv
module eep_line_sync
    import eep_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev_o
);
    logic [STAGES-1:0] scl_sh, sda_sh;
    logic scl_q, sda_q, scl_n, sda_n;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) begin
                    scl_sh[g] <= 1'b1;
                    sda_sh[g] <= 1'b1;
                end else if (g == 0) begin
                    scl_sh[g] <= scl_i;
                    sda_sh[g] <= sda_i;
                end else begin
                    scl_sh[g] <= scl_sh[(g == 0) ? 0 : g - 1];
                    sda_sh[g] <= sda_sh[(g == 0) ? 0 : g - 1];
                end
            end
        end
    endgenerate

    assign scl_n = scl_sh[STAGES-1];
    assign sda_n = sda_sh[STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_n;
            sda_q <= sda_n;
        end
    end

    always_comb begin
        ev_o.sda      = sda_n;
        ev_o.scl_rise = scl_n & ~scl_q;
        ev_o.scl_fall = ~scl_n & scl_q;
        ev_o.start    = scl_n & scl_q & sda_q & ~sda_n;
        ev_o.stop     = scl_n & scl_q & ~sda_q & sda_n;
    end
endmodule

// File: rtl/eep_store.sv
module eep_store #(
    parameter int ADDR_W    = 7,
    parameter int PAGE_W    = 3,
    parameter int WR_CYCLES = 1000
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         commit_i,
    input  logic [ADDR_W-PAGE_W-1:0]     base_i,
    input  logic [(1<<PAGE_W)-1:0][7:0]  lanes_i,
    input  logic [(1<<PAGE_W)-1:0]       mask_i,
    input  logic [ADDR_W-1:0]            rd_addr_i,
    output logic [7:0]                   rd_data_o,
    output logic                         busy_o
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int LANES = 1 << PAGE_W;
    localparam int CNT_W = $clog2(WR_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(WR_CYCLES);
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

    logic [7:0] mem [DEPTH];
    logic [CNT_W-1:0] left;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
        end else if (commit_i) begin
            for (int i = 0; i < LANES; i++)
                if (mask_i[i]) mem[{base_i, PAGE_W'(i)}] <= lanes_i[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)            left <= '0;
        else if (commit_i)  left <= CNT_LOAD;
        else if (busy_o)    left <= left - CNT_ONE;
    end

    assign busy_o    = left != '0;
    assign rd_data_o = mem[rd_addr_i];
endmodule

// File: rtl/twi_eeprom.sv
module twi_eeprom
    import eep_pkg::*;
#(
    parameter int ADDR_W      = 7,
    parameter int PAGE_W      = 3,
    parameter int WR_CYCLES   = 1000,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic sda_i,
    input  logic wr_en_i,
    output logic sda_oe_o
);
    localparam int LANES  = 1 << PAGE_W;
    localparam int BASE_W = ADDR_W - PAGE_W;
    localparam logic [PAGE_W-1:0] PTR_ONE  = PAGE_W'(1);
    localparam logic [ADDR_W-1:0] ADDR_ONE = ADDR_W'(1);

    bus_ev_t    ev;
    eep_state_e st;
    rx_kind_e   kind;
    logic [3:0] bcnt;
    logic [7:0] sh;
    logic       rw, mack_ok, busy, commit;
    logic [ADDR_W-1:0]        addr;
    logic [BASE_W-1:0]        pg_base;
    logic [PAGE_W-1:0]        pg_ptr;
    logic [LANES-1:0][7:0]    lanes;
    logic [LANES-1:0]         mask;
    logic [7:0]               rd_data;

    eep_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i), .ev_o(ev)
    );

    assign commit = ev.stop && (mask != '0) && wr_en_i;

    eep_store #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .WR_CYCLES(WR_CYCLES)) u_store (
        .clk(clk), .rst(rst), .commit_i(commit), .base_i(pg_base),
        .lanes_i(lanes), .mask_i(mask), .rd_addr_i(addr),
        .rd_data_o(rd_data), .busy_o(busy)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            kind     <= RX_DEV;
            bcnt     <= '0;
            sh       <= '0;
            rw       <= 1'b0;
            mack_ok  <= 1'b0;
            addr     <= '0;
            pg_base  <= '0;
            pg_ptr   <= '0;
            lanes    <= '0;
            mask     <= '0;
            sda_oe_o <= 1'b0;
        end else if (ev.start) begin
            st       <= ST_RX;
            kind     <= RX_DEV;
            bcnt     <= '0;
            mask     <= '0;
            sda_oe_o <= 1'b0;
        end else if (ev.stop) begin
            st       <= ST_IDLE;
            mask     <= '0;
            sda_oe_o <= 1'b0;
        end else begin
            case (st)
                ST_RX: begin
                    if (ev.scl_rise) begin
                        sh   <= {sh[6:0], ev.sda};
                        bcnt <= bcnt + 4'd1;
                    end else if (ev.scl_fall && bcnt == 4'd8) begin
                        bcnt <= '0;
                        case (kind)
                            RX_DEV: begin
                                if (dev_match(sh) && !busy) begin
                                    rw       <= sh[0];
                                    st       <= ST_ACK;
                                    sda_oe_o <= 1'b1;
                                end else begin
                                    st <= ST_IDLE;
                                end
                            end
                            RX_WADDR: begin
                                addr     <= sh[ADDR_W-1:0];
                                pg_base  <= sh[ADDR_W-1:PAGE_W];
                                pg_ptr   <= sh[PAGE_W-1:0];
                                st       <= ST_ACK;
                                sda_oe_o <= 1'b1;
                            end
                            default: begin
                                lanes[pg_ptr] <= sh;
                                mask[pg_ptr]  <= 1'b1;
                                pg_ptr        <= pg_ptr + PTR_ONE;
                                addr          <= {pg_base, pg_ptr + PTR_ONE};
                                st            <= ST_ACK;
                                sda_oe_o      <= 1'b1;
                            end
                        endcase
                    end
                end
                ST_ACK: begin
                    if (ev.scl_fall) begin
                        if (kind == RX_DEV && rw) begin
                            st       <= ST_TX;
                            sh       <= rd_data;
                            sda_oe_o <= ~rd_data[7];
                            addr     <= addr + ADDR_ONE;
                            bcnt     <= '0;
                        end else begin
                            st       <= ST_RX;
                            sda_oe_o <= 1'b0;
                            kind     <= (kind == RX_DEV) ? RX_WADDR : RX_WDATA;
                        end
                    end
                end
                ST_TX: begin
                    if (ev.scl_fall) begin
                        if (bcnt == 4'd7) begin
                            sda_oe_o <= 1'b0;
                            st       <= ST_MACK;
                            bcnt     <= '0;
                        end else begin
                            sh       <= {sh[6:0], 1'b0};
                            sda_oe_o <= ~sh[6];
                            bcnt     <= bcnt + 4'd1;
                        end
                    end
                end
                ST_MACK: begin
                    if (ev.scl_rise) begin
                        mack_ok <= ~ev.sda;
                    end else if (ev.scl_fall) begin
                        if (mack_ok) begin
                            st       <= ST_TX;
                            sh       <= rd_data;
                            sda_oe_o <= ~rd_data[7];
                            addr     <= addr + ADDR_ONE;
                            bcnt     <= '0;
                        end else begin
                            st <= ST_IDLE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/twi_eeprom_chk.sv
module twi_eeprom_chk
    import eep_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       start_i,
    input logic       stop_i,
    input logic       fall_i,
    input logic       oe_i,
    input logic       busy_i,
    input logic       wc_i,
    input eep_state_e st_i,
    input rx_kind_e   kind_i
);
    AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (rst)
        stop_i |=> !oe_i); // R11

    AST_OE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!$past(fall_i) && !$past(start_i) && !$past(stop_i)) |-> $stable(oe_i)); // R11

    AST_OE_SLOTS: assert property (@(posedge clk) disable iff (rst)
        (st_i != ST_ACK && st_i != ST_TX) |-> !oe_i); // R10

    AST_BUSY_FROM_STOP: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_i) |-> $past(stop_i)); // R5

    AST_BUSY_NEEDS_WC: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_i) |-> $past(wc_i)); // R9

    AST_NO_SELECT_BUSY: assert property (@(posedge clk) disable iff (rst)
        ($past(st_i) == ST_RX && st_i == ST_ACK && kind_i == RX_DEV) |-> !$past(busy_i)); // R5
endmodule

bind twi_eeprom twi_eeprom_chk u_chk (
    .clk(clk), .rst(rst), .start_i(ev.start), .stop_i(ev.stop),
    .fall_i(ev.scl_fall), .oe_i(sda_oe_o), .busy_i(busy), .wc_i(wr_en_i),
    .st_i(st), .kind_i(kind)
);

// File: tb/twi_eeprom_bench.sv
module twi_eeprom_bench;
    localparam int WRC  = 300;
    localparam int HALF = 8;

    logic clk = 1'b0, rst = 1'b1, scl_m = 1'b1, sda_m = 1'b1, wc = 1'b1;
    logic sda_oe;
    logic sda_line;
    assign sda_line = sda_m & ~sda_oe;

    twi_eeprom #(.WR_CYCLES(WRC)) u_twi_eeprom (
        .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line),
        .wr_en_i(wc), .sda_oe_o(sda_oe)
    );

    always #10 clk = ~clk;

    int total = 0, bad = 0;
    byte unsigned ref_mem [128];
    byte unsigned dat [16];
    int ref_ptr = 0;

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic bit_tx(input logic b);
        tick(HALF/2); sda_m = b; tick(HALF/2);
        scl_m = 1'b1; tick(HALF); scl_m = 1'b0;
    endtask

    task automatic bit_rx(output logic r);
        sda_m = 1'b1; tick(HALF);
        scl_m = 1'b1; tick(HALF/2); r = sda_line; tick(HALF/2);
        scl_m = 1'b0;
    endtask

    task automatic do_start();
        tick(HALF/2); sda_m = 1'b1; tick(HALF/2);
        scl_m = 1'b1; tick(HALF/2); sda_m = 1'b0; tick(HALF/2);
        scl_m = 1'b0;
    endtask

    task automatic do_stop();
        tick(HALF/2); sda_m = 1'b0; tick(HALF/2);
        scl_m = 1'b1; tick(HALF/2); sda_m = 1'b1; tick(HALF);
    endtask

    task automatic send_byte(input byte unsigned b, output logic acked);
        logic r;
        for (int i = 7; i >= 0; i--) bit_tx(b[i]);
        bit_rx(r);
        acked = ~r;
    endtask

    task automatic recv_byte(input logic mack, output byte unsigned d);
        logic r;
        for (int i = 7; i >= 0; i--) begin bit_rx(r); d[i] = r; end
        bit_tx(~mack);
    endtask

    function automatic byte unsigned sel_byte(input logic rd);
        return byte'({4'b1010, 3'($urandom_range(0, 7)), rd});
    endfunction

    function automatic int page_loc(input int a, input int k);
        return (a & 8'h78) | ((a + k) & 7);
    endfunction

    // returns 1 if the select was acknowledged
    task automatic poll(output logic acked);
        do_start(); send_byte(sel_byte(1'b0), acked); do_stop();
    endtask

    task automatic wait_ready(input string req);
        logic a;
        int n = 0;
        do begin poll(a); n++; end while (!a && n < 20);
        check({req, " ready after write cycle"}, a, 1);
    endtask

    task automatic write_tx(input int a, input int n, input string req);
        logic ak;
        do_start();
        send_byte(sel_byte(1'b0), ak); check({req, " select ack"}, ak, 1);
        send_byte(byte'(a), ak);       check({req, " address ack"}, ak, 1);
        for (int k = 0; k < n; k++) begin
            send_byte(dat[k], ak);     check({req, " data ack"}, ak, 1);
            if (wc) ref_mem[page_loc(a, k)] = dat[k];
        end
        do_stop();
        ref_ptr = (n == 0) ? (a & 8'h7F) : page_loc(a, n);
    endtask

    task automatic read_body(input int n, input string req);
        byte unsigned d;
        for (int k = 0; k < n; k++) begin
            recv_byte(k != n - 1, d);
            check(req, d, ref_mem[ref_ptr]);
            ref_ptr = (ref_ptr + 1) & 8'h7F;
        end
        do_stop();
    endtask

    task automatic read_rand(input int a, input int n, input string req);
        logic ak;
        do_start();
        send_byte(sel_byte(1'b0), ak); check({req, " select ack"}, ak, 1);
        send_byte(byte'(a), ak);       check({req, " address ack"}, ak, 1);
        do_start();
        send_byte(sel_byte(1'b1), ak); check({req, " read select ack"}, ak, 1);
        ref_ptr = a & 8'h7F;
        read_body(n, req);
    endtask

    task automatic read_cur(input int n, input string req);
        logic ak;
        do_start();
        send_byte(sel_byte(1'b1), ak); check({req, " read select ack"}, ak, 1);
        read_body(n, req);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic ak;
        byte unsigned d;
        void'($urandom(32'h5EED_0042));
        for (int i = 0; i < 128; i++) ref_mem[i] = 8'hFF;
        tick(5);
        check("R1 line released in reset", sda_oe, 0);
        rst = 1'b0;
        tick(5);
        check("R1 line released after reset", sda_oe, 0);
        read_rand(8'h00, 4, "R1 erased");
        read_rand(8'h7D, 3, "R1 erased top");

        // byte write and read back
        dat[0] = 8'h5A;
        write_tx(8'h10, 1, "R3 byte write");
        poll(ak); check("R5 select refused in write cycle", ak, 0);
        wait_ready("R5");
        read_rand(8'h10, 1, "R6 random read");

        // page write with wrap inside the page
        for (int k = 0; k < 10; k++) dat[k] = byte'(8'hA0 + k);
        write_tx(8'h3B, 10, "R4 page wrap");
        wait_ready("R4");
        read_rand(8'h38, 8, "R4 page contents");
        read_rand(8'h40, 1, "R4 next page untouched");

        // counter after a write
        for (int k = 0; k < 3; k++) dat[k] = byte'(8'h11 * (k + 1));
        write_tx(8'h45, 3, "R3 short page");
        wait_ready("R3");
        read_cur(2, "R7 counter after write");
        read_cur(1, "R7 counter advance");

        // dummy write stores nothing: address then repeated start
        dat[0] = 8'h77;
        read_rand(8'h20, 2, "R6 dummy write");
        poll(ak); check("R6 no write cycle after dummy", ak, 1);

        // rollover
        read_rand(8'h7C, 8, "R8 rollover");

        // write control low
        wc = 1'b0;
        dat[0] = 8'h00; dat[1] = 8'h01;
        write_tx(8'h10, 2, "R9 inhibited");
        poll(ak); check("R9 no write cycle when inhibited", ak, 1);
        wc = 1'b1;
        read_rand(8'h10, 2, "R9 unchanged");

        // wrong select code, then bus ignored
        do_start();
        send_byte(8'h50, ak); check("R2 foreign code refused", ak, 0);
        send_byte(8'hA0, ak); check("R2 ignored until start", ak, 0);
        do_stop();
        read_rand(8'h38, 2, "R2 intact after foreign code");

        // missing master ack ends the read
        do_start();
        send_byte(8'hA1, ak); check("R10 read select ack", ak, 1);
        recv_byte(1'b0, d); check("R10 single byte", d, ref_mem[ref_ptr]);
        ref_ptr = (ref_ptr + 1) & 8'h7F;
        send_byte(8'hA1, ak); check("R10 ignored after nack", ak, 0);
        do_stop();
        read_cur(1, "R10 counter after nack");

        // constrained random mix
        for (int it = 0; it < 20; it++) begin
            int op, a, n;
            op = $urandom_range(0, 2);
            a  = $urandom_range(0, 127);
            if (op == 0) begin
                n = $urandom_range(1, 10);
                for (int k = 0; k < n; k++) dat[k] = byte'($urandom);
                write_tx(a, n, "R3 random write");
                wait_ready("R5");
            end else if (op == 1) begin
                read_rand(a, $urandom_range(1, 12), "R8 random read");
            end else begin
                read_cur($urandom_range(1, 5), "R7 random current read");
            end
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule